// File: doc/BRIEF.md
# Dual-Port RAM with Write-Collision Tracking

This block is a synchronous memory with two fully independent read/write ports, A and B, sharing one clock. In each cycle and on each port, the enable, write-enable and port-clear inputs choose one operation: idle, clear, read or write. The choice on one port does not depend on the other port. A write is write-first: the port's data output shows the word being written. A read returns the word that was stored before the edge.

When both ports write the same address in the same cycle, neither word is kept. The location is marked corrupt. From then on, any read of that location, from either port, returns a poison word of all ones and raises that port's invalid flag. This lasts until one port writes the location again without a collision. The flag lets the surrounding logic detect a lost write instead of taking an arbitrary winner. There is no streaming data path, so the ports are plain, level-driven memory pins.

Top module: `dpram_collide`

## Requirements
- R1: An enabled write (en=1, we=1, clr=0) loads that port's rdata with its own wdata and clears its bad flag, both visible after the clock edge.
- R2: A write with no same-address write from the other port in that cycle stores the word. A later read from either port returns that word with bad low.
- R3: When both ports write the same address in one cycle, each port still shows its own wdata with bad low. The location is marked corrupt and its contents are not updated.
- R4: A read of a corrupt location makes that port's rdata all ones (the poison word) and raises its bad flag. This holds for both port A and port B.
- R5: A read of a valid location loads rdata with the stored word and drives bad low.
- R6: If one port writes and the other port reads the same address in one cycle, the reader gets the contents and validity from before that edge. The write completes normally and does not mark the location corrupt.
- R7: With en low, a port does no access: its rdata and bad hold their values, and its we, clr, addr and wdata have no effect.
- R8: With en and clr both high, a port's rdata is cleared to zero and bad goes low. No write occurs even if we is high. With en low, clr is ignored.
- R9: While rst_n is low, every location is set to zero and marked valid, and both ports' rdata and bad are cleared.
- R10: A clean write to a corrupt location makes it valid again. A following read returns the newly written word with bad low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset of the whole array and both output registers |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write enable |
| a_clr | input | 1 | Port A synchronous output clear (acts only with a_en) |
| a_addr | input | AW | Port A address |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A registered output data |
| a_bad | output | 1 | Port A flag: a_rdata came from a corrupt location |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write enable |
| b_clr | input | 1 | Port B synchronous output clear (acts only with b_en) |
| b_addr | input | AW | Port B address |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B registered output data |
| b_bad | output | 1 | Port B flag: b_rdata came from a corrupt location |

## Verification
The bound assertions check the per-port rules on every cycle:
- write-first output,
- hold while disabled,
- the clear,
- the poison word whenever the flag is high,
- the two one-cycle-apart cases: a collision followed by a same-address read, and a clean cross-port write followed by a read.

Only the bench's scenarios can show behaviour spread over many cycles and addresses. This covers corruption persisting through unrelated traffic, a clean rewrite restoring validity, and reads of old data during a same-cycle write. The bench's reference model tracks contents and validity for every address and compares both ports on every clock.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_CLR  = 2'd1,
    OP_RD   = 2'd2,
    OP_WR   = 2'd3
  } port_op_e;

  function automatic port_op_e decode_op(input logic en, input logic we, input logic clr);
    if (!en)      return OP_IDLE;
    else if (clr) return OP_CLR;
    else if (we)  return OP_WR;
    else          return OP_RD;
  endfunction

endpackage

// File: rtl/dpc_store.sv
module dpc_store #(
  parameter int AW = 8,
  parameter int DW = 16,
  parameter int NP = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NP-1:0]          wr,
  input  logic [NP-1:0][AW-1:0]  addr,
  input  logic [NP-1:0][DW-1:0]  wdata,
  input  logic                   clash,
  output logic [NP-1:0][DW-1:0]  rd_word,
  output logic [NP-1:0]          rd_ok
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] ok_bits;

  // Old contents are read before the edge; new writes land after it.
  for (genvar p = 0; p < NP; p++) begin : g_rd
    assign rd_word[p] = mem[addr[p]];
    assign rd_ok[p]   = ok_bits[addr[p]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      ok_bits <= '1;
    end else begin
      for (int p = 0; p < NP; p++) begin
        if (wr[p] && !clash) begin
          mem[addr[p]]     <= wdata[p];
          ok_bits[addr[p]] <= 1'b1;
        end
      end
      if (clash) ok_bits[addr[0]] <= 1'b0;
    end
  end

endmodule

// File: rtl/dpc_port.sv
module dpc_port
  import dpc_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  port_op_e      op,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] mem_word,
  input  logic          mem_ok,
  output logic [DW-1:0] rdata,
  output logic          bad
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
      bad   <= 1'b0;
    end else begin
      unique case (op)
        OP_CLR: begin
          rdata <= '0;
          bad   <= 1'b0;
        end
        OP_WR: begin
          rdata <= wdata;
          bad   <= 1'b0;
        end
        OP_RD: begin
          rdata <= mem_ok ? mem_word : '1;
          bad   <= !mem_ok;
        end
        default: begin
          rdata <= rdata;
          bad   <= bad;
        end
      endcase
    end
  end

endmodule

// File: rtl/dpram_collide.sv
module dpram_collide
  import dpc_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_en,
  input  logic          a_we,
  input  logic          a_clr,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_bad,
  input  logic          b_en,
  input  logic          b_we,
  input  logic          b_clr,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_bad
);
  localparam int NP = 2;

  logic [NP-1:0]         en, we, clr, wr, bad;
  logic [NP-1:0][AW-1:0] addr;
  logic [NP-1:0][DW-1:0] wdata, rdata, mem_word;
  logic [NP-1:0]         mem_ok;
  port_op_e              op [NP];
  logic                  clash;

  assign en    = {b_en, a_en};
  assign we    = {b_we, a_we};
  assign clr   = {b_clr, a_clr};
  assign addr  = {b_addr, a_addr};
  assign wdata = {b_wdata, a_wdata};

  for (genvar p = 0; p < NP; p++) begin : g_port
    assign op[p] = decode_op(en[p], we[p], clr[p]);
    assign wr[p] = (op[p] == OP_WR);

    dpc_port #(.DW(DW)) u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op[p]),
      .wdata    (wdata[p]),
      .mem_word (mem_word[p]),
      .mem_ok   (mem_ok[p]),
      .rdata    (rdata[p]),
      .bad      (bad[p])
    );
  end

  assign clash = wr[0] && wr[1] && (addr[0] == addr[1]);

  dpc_store #(.AW(AW), .DW(DW), .NP(NP)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (wr),
    .addr    (addr),
    .wdata   (wdata),
    .clash   (clash),
    .rd_word (mem_word),
    .rd_ok   (mem_ok)
  );

  assign a_rdata = rdata[0];
  assign b_rdata = rdata[1];
  assign a_bad   = bad[0];
  assign b_bad   = bad[1];

endmodule

// File: rtl/dpc_chk.sv
module dpc_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_en,
  input logic          a_we,
  input logic          a_clr,
  input logic [AW-1:0] a_addr,
  input logic [DW-1:0] a_wdata,
  input logic [DW-1:0] a_rdata,
  input logic          a_bad,
  input logic          b_en,
  input logic          b_we,
  input logic          b_clr,
  input logic [AW-1:0] b_addr,
  input logic [DW-1:0] b_wdata,
  input logic [DW-1:0] b_rdata,
  input logic          b_bad
);
  logic a_wr, b_wr, a_rd, both_wr_same;
  assign a_wr = a_en && a_we && !a_clr;
  assign b_wr = b_en && b_we && !b_clr;
  assign a_rd = a_en && !a_we && !a_clr;
  assign both_wr_same = a_wr && b_wr && (a_addr == b_addr);

  // R1
  a_write_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_wr |=> (a_rdata == $past(a_wdata)) && !a_bad);

  // R1
  b_write_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_wr |=> (b_rdata == $past(b_wdata)) && !b_bad);

  // R7
  a_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !a_en |=> $stable(a_rdata) && $stable(a_bad));

  // R7
  b_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !b_en |=> $stable(b_rdata) && $stable(b_bad));

  // R8
  a_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && a_clr) |=> (a_rdata == '0) && !a_bad);

  // R8
  b_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_en && b_clr) |=> (b_rdata == '0) && !b_bad);

  // R4
  a_poison_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_bad |-> (a_rdata == '1));

  // R4
  b_poison_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_bad |-> (b_rdata == '1));

  // R3
  collide_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rd && $past(both_wr_same) && (a_addr == $past(a_addr))) |=> a_bad);

  // R2
  cross_write_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_rd && $past(b_wr && !both_wr_same) && (a_addr == $past(b_addr)))
      |=> (a_rdata == $past(b_wdata, 2)) && !a_bad);

endmodule

bind dpram_collide dpc_chk #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/dpram_collide_test.sv
module dpram_collide_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic          en [2];
  logic          we [2];
  logic          clr [2];
  logic [AW-1:0] addr [2];
  logic [DW-1:0] wd [2];
  logic [DW-1:0] a_rdata, b_rdata;
  logic          a_bad, b_bad;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  logic [DW-1:0] m_mem [DEPTH];
  bit            m_ok  [DEPTH];
  logic [DW-1:0] e_d [2];
  bit            e_b [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dpram_collide #(.AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .a_en(en[0]), .a_we(we[0]), .a_clr(clr[0]), .a_addr(addr[0]), .a_wdata(wd[0]),
    .a_rdata(a_rdata), .a_bad(a_bad),
    .b_en(en[1]), .b_we(we[1]), .b_clr(clr[1]), .b_addr(addr[1]), .b_wdata(wd[1]),
    .b_rdata(b_rdata), .b_bad(b_bad)
  );

  function automatic logic [DW-1:0] got_d(int p);
    return (p == 0) ? a_rdata : b_rdata;
  endfunction

  function automatic bit got_b(int p);
    return (p == 0) ? a_bad : b_bad;
  endfunction

  task automatic chk(string tag, logic [DW-1:0] gd, bit gb, logic [DW-1:0] xd, bit xb);
    vectors++;
    if (gd !== xd || gb !== xb) begin
      miscompares++;
      $display("FAIL %s: got data=%h bad=%0b, expected data=%h bad=%0b", tag, gd, gb, xd, xb);
    end
  endtask

  task automatic set_port(int p, bit e, bit w, bit c, logic [AW-1:0] a, logic [DW-1:0] d);
    en[p] = e; we[p] = w; clr[p] = c; addr[p] = a; wd[p] = d;
  endtask

  // One clock: predict, clock, update model, compare both ports at the falling edge.
  task automatic tick();
    string tag [2];
    bit wr [2];
    bit clash;
    for (int p = 0; p < 2; p++) wr[p] = en[p] && !clr[p] && we[p];
    clash = wr[0] && wr[1] && (addr[0] == addr[1]);
    for (int p = 0; p < 2; p++) begin
      if (!en[p]) tag[p] = "R7 idle hold";
      else if (clr[p]) begin tag[p] = "R8 port clear"; e_d[p] = '0; e_b[p] = 0; end
      else if (we[p]) begin
        tag[p] = clash ? "R3 collide own data" : "R1 write-first";
        e_d[p] = wd[p]; e_b[p] = 0;
      end else begin
        if (wr[1-p] && addr[1-p] == addr[p]) tag[p] = "R6 read during write";
        else tag[p] = m_ok[addr[p]] ? "R5 valid read" : "R4 poison read";
        e_d[p] = m_ok[addr[p]] ? m_mem[addr[p]] : '1;
        e_b[p] = !m_ok[addr[p]];
      end
    end
    @(posedge clk);
    for (int p = 0; p < 2; p++)
      if (wr[p] && !clash) begin m_mem[addr[p]] = wd[p]; m_ok[addr[p]] = 1; end
    if (clash) m_ok[addr[0]] = 0;
    @(negedge clk);
    for (int p = 0; p < 2; p++) chk(tag[p], got_d(p), got_b(p), e_d[p], e_b[p]);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
  end

  initial begin
    for (int p = 0; p < 2; p++) set_port(p, 0, 0, 0, '0, '0);
    for (int i = 0; i < DEPTH; i++) begin m_mem[i] = '0; m_ok[i] = 1; end
    e_d[0] = '0; e_d[1] = '0; e_b[0] = 0; e_b[1] = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R9: reset state on outputs
    chk("R9 reset A", a_rdata, a_bad, '0, 0);
    chk("R9 reset B", b_rdata, b_bad, '0, 0);
    rst_n = 1'b1;

    // R9: memory is zero and valid after reset
    set_port(0, 1, 0, 0, 8'd200, '0); set_port(1, 1, 0, 0, 8'd255, '0); tick();
    chk("R9 zero valid A", a_rdata, a_bad, 16'h0000, 0);
    chk("R9 zero valid B", b_rdata, b_bad, 16'h0000, 0);

    // R1, R2: A writes, B reads it the next cycle
    set_port(0, 1, 1, 0, 8'h05, 16'h1234); set_port(1, 0, 0, 0, '0, '0); tick();
    chk("R1 write-first A", a_rdata, a_bad, 16'h1234, 0);
    set_port(0, 0, 0, 0, '0, '0); set_port(1, 1, 0, 0, 8'h05, '0); tick();
    chk("R2 cross-port read B", b_rdata, b_bad, 16'h1234, 0);

    // R6: B writes 0x05, A reads 0x05 same cycle -> old value
    set_port(0, 1, 0, 0, 8'h05, '0); set_port(1, 1, 1, 0, 8'h05, 16'hBEEF); tick();
    chk("R6 old value A", a_rdata, a_bad, 16'h1234, 0);
    set_port(1, 0, 0, 0, '0, '0); tick();
    chk("R6 write completed A", a_rdata, a_bad, 16'hBEEF, 0);

    // R3: both write 0x0F
    set_port(0, 1, 1, 0, 8'h0F, 16'hAAAA); set_port(1, 1, 1, 0, 8'h0F, 16'h5555); tick();
    chk("R3 own data A", a_rdata, a_bad, 16'hAAAA, 0);
    chk("R3 own data B", b_rdata, b_bad, 16'h5555, 0);
    // R4: both read it
    set_port(0, 1, 0, 0, 8'h0F, '0); set_port(1, 1, 0, 0, 8'h0F, '0); tick();
    chk("R4 poison A", a_rdata, a_bad, 16'hFFFF, 1);
    chk("R4 poison B", b_rdata, b_bad, 16'hFFFF, 1);

    // R7: disabled port ignores we/clr/addr/data
    set_port(0, 0, 1, 1, 8'h0F, 16'h0101); set_port(1, 0, 1, 0, 8'h0F, 16'h0202); tick();
    chk("R7 hold A", a_rdata, a_bad, 16'hFFFF, 1);
    set_port(0, 1, 0, 0, 8'h0F, '0); set_port(1, 0, 0, 0, '0, '0); tick();
    chk("R7 no write while idle", a_rdata, a_bad, 16'hFFFF, 1);

    // R8: clear with we high does not write
    set_port(0, 1, 1, 1, 8'h0F, 16'h7777); tick();
    chk("R8 clear A", a_rdata, a_bad, 16'h0000, 0);
    set_port(0, 0, 0, 0, '0, '0); set_port(1, 1, 0, 0, 8'h0F, '0); tick();
    chk("R8 no write on clear", b_rdata, b_bad, 16'hFFFF, 1);

    // R10: clean rewrite restores validity
    set_port(0, 1, 1, 0, 8'h0F, 16'h2222); set_port(1, 0, 0, 0, '0, '0); tick();
    set_port(0, 0, 0, 0, '0, '0); set_port(1, 1, 0, 0, 8'h0F, '0); tick();
    chk("R10 restored B", b_rdata, b_bad, 16'h2222, 0);

    // Random traffic over a small address set to force collisions
    for (int n = 0; n < 4000; n++) begin
      for (int p = 0; p < 2; p++) begin
        int r;
        logic [AW-1:0] a;
        r = $urandom_range(0, 4);
        a = (r == 4) ? 8'hFF : 8'(r);
        set_port(p, $urandom_range(0, 9) != 0, $urandom_range(0, 1), $urandom_range(0, 15) == 0,
                 a, 16'($urandom));
      end
      tick();
    end
    summary();
  end

endmodule